// File: doc/BRIEF.md
# Mode-Residency Energy Accumulator

A sensor node has a radio and a CPU, and each one is always in a known power mode. This block counts how many ticks each part spends in each mode, so that a later stage can estimate consumption. A tick enable advances four saturating counters: radio transmit, radio listen, CPU active and CPU low-power. Status inputs pick which counters move on each tick. The radio pair never advances together, and exactly one counter of the CPU pair moves on every tick. The sum of the two CPU counters is therefore the node's uptime in ticks.

A snapshot request does two things:
- It captures the four counts, the four per-mode current coefficients (microamps) and the supply code (millivolts).
- It starts a sequential computation on one shared multiplier.

The computation produces five results:
- a weighted current estimate;
- uptime in whole seconds;
- charge;
- energy;
- power.

The tick rate is fixed at 32768 per second, so every time conversion is a 15-bit right shift. The counters keep running while the computation is in progress. A one-cycle done pulse marks the moment the results are valid.

Top module: `mode_energy_acc`

## Requirements
- R1: While and after reset, all four counters read zero, and conflict_err, busy and done are low.
- R2: A counter changes only on a cycle where tick_en is high. With tick_en low, the mode inputs have no effect on any count.
- R3: On a tick, tx_on advances the transmit counter and rx_on advances the listen counter. The two radio counters never both advance on the same tick.
- R4: If tx_on and rx_on are both high on a tick, only the transmit counter advances. conflict_err then goes high on the next cycle and stays high until reset.
- R5: On every tick exactly one CPU counter advances: active when cpu_active is 1, low-power when it is 0.
- R6: A radio counter and the CPU active counter both advance when their modes coincide on one tick.
- R7: Each counter stops at 2^CNT_W-1 and never wraps.
- R8: cur_est equals floor((tx·c_tx + rx·c_rx + act·c_act + lpm·c_lpm) / 32768), using the captured counts and coefficients.
- R9: uptime_s equals floor((act + lpm) / 32768).
- R10: charge_uc equals floor(cur_est · (act + lpm) / 32768).
- R11: energy_nj equals charge_uc · volt_mv, and power_nw equals cur_est · volt_mv, both using the captured supply code.
- R12: busy is high from the cycle after snap_req is sampled in the idle state. All results update and done pulses high for one cycle after the 8th rising edge following the sampling edge.
- R13: Counts, coefficients and supply code are frozen at the sampling edge. Later changes to them, continued counting, and snap_req while busy have no effect on that snapshot's results, and no extra done pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One residency tick this cycle |
| tx_on | input | 1 | Radio is transmitting |
| rx_on | input | 1 | Radio is listening |
| cpu_active | input | 1 | CPU is active (0 = low-power) |
| coef_tx | input | COEF_W | Transmit current, µA |
| coef_rx | input | COEF_W | Listen current, µA |
| coef_act | input | COEF_W | CPU active current, µA |
| coef_lpm | input | COEF_W | CPU low-power current, µA |
| volt_mv | input | VOLT_W | Supply, mV |
| snap_req | input | 1 | Start a snapshot computation |
| cnt_tx | output | CNT_W | Transmit tick count |
| cnt_rx | output | CNT_W | Listen tick count |
| cnt_act | output | CNT_W | CPU active tick count |
| cnt_lpm | output | CNT_W | CPU low-power tick count |
| conflict_err | output | 1 | Sticky: both radio modes seen on one tick |
| busy | output | 1 | Snapshot computation in progress |
| done | output | 1 | One-cycle pulse, results valid |
| cur_est | output | CUR_W | Weighted current estimate |
| uptime_s | output | UPS_W | Uptime in seconds |
| charge_uc | output | CHG_W | Charge, µC |
| energy_nj | output | ENG_W | Energy, nJ |
| power_nw | output | PWR_W | Power, nW |

## Verification
Counter effects are due one edge after the tick that causes them. The bench drives inputs on the falling edge and reads the counters on the next falling edge, one rising edge later. The conflict flag follows the same one-edge timing. Snapshot results and done are due exactly eight rising edges after the edge that samples snap_req. The bench steps through those edges one at a time, treats any earlier done as a failure, and compares every result at the falling edge after the eighth. That value is then checked against counts and settings that the bench itself captured before the request.

// File: rtl/mea_pkg.sv
package mea_pkg;
  localparam int NUM_MODES = 4;
  localparam int MODE_TX   = 0;
  localparam int MODE_RX   = 1;
  localparam int MODE_ACT  = 2;
  localparam int MODE_LPM  = 3;
  // 32768 ticks per second
  localparam int TPS_SHIFT = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MAC, ST_CUR, ST_CHG, ST_ENG, ST_PWR
  } snap_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mea_mode_counter.sv
module mea_mode_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && count != TOP)
      count <= count + 1'b1;
  end

  // R7: a full counter stays full
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    count == TOP |=> count == TOP);
  // R2: without an increment the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));
endmodule

// File: rtl/mea_snapshot.sv
module mea_snapshot
  import mea_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int COEF_W = 16,
  parameter int VOLT_W = 16,
  localparam int WS_W  = CNT_W + COEF_W + 2,
  localparam int CUR_W = WS_W - TPS_SHIFT,
  localparam int UPT_W = CNT_W + 1,
  localparam int UPS_W = UPT_W - TPS_SHIFT,
  localparam int CHG_W = CUR_W + UPT_W - TPS_SHIFT,
  localparam int ENG_W = CHG_W + VOLT_W,
  localparam int PWR_W = CUR_W + VOLT_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic [NUM_MODES-1:0][CNT_W-1:0]    cnt_in,
  input  logic [NUM_MODES-1:0][COEF_W-1:0]   coef_in,
  input  logic [VOLT_W-1:0]                  volt_in,
  output logic                               busy,
  output logic                               done,
  output logic [CUR_W-1:0]                   cur_o,
  output logic [UPS_W-1:0]                   upt_o,
  output logic [CHG_W-1:0]                   chg_o,
  output logic [ENG_W-1:0]                   eng_o,
  output logic [PWR_W-1:0]                   pwr_o
);
  localparam int MA_W = imax(CHG_W, imax(CUR_W, CNT_W));
  localparam int MB_W = imax(UPT_W, imax(COEF_W, VOLT_W));
  localparam int PR_W = imax(imax(WS_W, CUR_W + UPT_W), imax(ENG_W, PWR_W));

  snap_state_t                       state;
  logic [1:0]                        idx;
  logic [NUM_MODES-1:0][CNT_W-1:0]   cnt_q;
  logic [NUM_MODES-1:0][COEF_W-1:0]  coef_q;
  logic [VOLT_W-1:0]                 volt_q;
  logic [WS_W-1:0]                   acc;
  logic [CUR_W-1:0]                  cur_q;
  logic [UPT_W-1:0]                  tick_sum;
  logic [CHG_W-1:0]                  chg_q;
  logic [ENG_W-1:0]                  eng_q;
  logic [MA_W-1:0]                   mul_a;
  logic [MB_W-1:0]                   mul_b;
  logic [PR_W-1:0]                   product;

  // single shared multiplier, operands chosen by the step in progress
  always_comb begin
    mul_a = '0;
    mul_b = '0;
    case (state)
      ST_MAC: begin mul_a = MA_W'(cnt_q[idx]); mul_b = MB_W'(coef_q[idx]); end
      ST_CHG: begin mul_a = MA_W'(cur_q);      mul_b = MB_W'(tick_sum);     end
      ST_ENG: begin mul_a = MA_W'(chg_q);      mul_b = MB_W'(volt_q);       end
      ST_PWR: begin mul_a = MA_W'(cur_q);      mul_b = MB_W'(volt_q);       end
      default: ;
    endcase
  end
  assign product = PR_W'(mul_a) * PR_W'(mul_b);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      cnt_q    <= '0;
      coef_q   <= '0;
      volt_q   <= '0;
      acc      <= '0;
      cur_q    <= '0;
      tick_sum <= '0;
      chg_q    <= '0;
      eng_q    <= '0;
      done     <= 1'b0;
      cur_o    <= '0;
      upt_o    <= '0;
      chg_o    <= '0;
      eng_o    <= '0;
      pwr_o    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cnt_q  <= cnt_in;
          coef_q <= coef_in;
          volt_q <= volt_in;
          acc    <= '0;
          idx    <= '0;
          state  <= ST_MAC;
        end
        ST_MAC: begin
          acc <= acc + product[WS_W-1:0];
          idx <= idx + 1'b1;
          if (idx == 2'(NUM_MODES - 1)) state <= ST_CUR;
        end
        ST_CUR: begin
          cur_q    <= acc[WS_W-1:TPS_SHIFT];
          tick_sum <= UPT_W'(cnt_q[MODE_ACT]) + UPT_W'(cnt_q[MODE_LPM]);
          state    <= ST_CHG;
        end
        ST_CHG: begin
          chg_q <= product[TPS_SHIFT +: CHG_W];
          state <= ST_ENG;
        end
        ST_ENG: begin
          eng_q <= product[ENG_W-1:0];
          state <= ST_PWR;
        end
        ST_PWR: begin
          cur_o <= cur_q;
          upt_o <= tick_sum[UPT_W-1:TPS_SHIFT];
          chg_o <= chg_q;
          eng_o <= eng_q;
          pwr_o <= product[PWR_W-1:0];
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12: an accepted request makes the engine busy
  a_r12_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R12: done arrives only once the engine is idle again
  a_r12_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R12: done lasts a single cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R13: captured operands do not move during a computation
  a_r13_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cnt_q) && $stable(coef_q) && $stable(volt_q)));
endmodule

// File: rtl/mode_energy_acc.sv
module mode_energy_acc
  import mea_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int COEF_W = 16,
  parameter int VOLT_W = 16,
  localparam int WS_W  = CNT_W + COEF_W + 2,
  localparam int CUR_W = WS_W - TPS_SHIFT,
  localparam int UPT_W = CNT_W + 1,
  localparam int UPS_W = UPT_W - TPS_SHIFT,
  localparam int CHG_W = CUR_W + UPT_W - TPS_SHIFT,
  localparam int ENG_W = CHG_W + VOLT_W,
  localparam int PWR_W = CUR_W + VOLT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              tx_on,
  input  logic              rx_on,
  input  logic              cpu_active,
  input  logic [COEF_W-1:0] coef_tx,
  input  logic [COEF_W-1:0] coef_rx,
  input  logic [COEF_W-1:0] coef_act,
  input  logic [COEF_W-1:0] coef_lpm,
  input  logic [VOLT_W-1:0] volt_mv,
  input  logic              snap_req,
  output logic [CNT_W-1:0]  cnt_tx,
  output logic [CNT_W-1:0]  cnt_rx,
  output logic [CNT_W-1:0]  cnt_act,
  output logic [CNT_W-1:0]  cnt_lpm,
  output logic              conflict_err,
  output logic              busy,
  output logic              done,
  output logic [CUR_W-1:0]  cur_est,
  output logic [UPS_W-1:0]  uptime_s,
  output logic [CHG_W-1:0]  charge_uc,
  output logic [ENG_W-1:0]  energy_nj,
  output logic [PWR_W-1:0]  power_nw
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [NUM_MODES-1:0]              mode_inc;
  logic [NUM_MODES-1:0][CNT_W-1:0]   counts;
  logic [NUM_MODES-1:0][COEF_W-1:0]  coefs;
  logic [CNT_W:0]                    cpu_sum;

  // transmit wins over listen when both are reported
  always_comb begin
    mode_inc           = '0;
    mode_inc[MODE_TX]  = tick_en & tx_on;
    mode_inc[MODE_RX]  = tick_en & rx_on & ~tx_on;
    mode_inc[MODE_ACT] = tick_en & cpu_active;
    mode_inc[MODE_LPM] = tick_en & ~cpu_active;
  end

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    mea_mode_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (mode_inc[m]),
      .count (counts[m])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      conflict_err <= 1'b0;
    else if (tick_en && tx_on && rx_on)
      conflict_err <= 1'b1;
  end

  assign cnt_tx  = counts[MODE_TX];
  assign cnt_rx  = counts[MODE_RX];
  assign cnt_act = counts[MODE_ACT];
  assign cnt_lpm = counts[MODE_LPM];

  assign coefs[MODE_TX]  = coef_tx;
  assign coefs[MODE_RX]  = coef_rx;
  assign coefs[MODE_ACT] = coef_act;
  assign coefs[MODE_LPM] = coef_lpm;

  mea_snapshot #(.CNT_W(CNT_W), .COEF_W(COEF_W), .VOLT_W(VOLT_W)) u_snap (
    .clk     (clk),
    .rst     (rst),
    .start   (snap_req),
    .cnt_in  (counts),
    .coef_in (coefs),
    .volt_in (volt_mv),
    .busy    (busy),
    .done    (done),
    .cur_o   (cur_est),
    .upt_o   (uptime_s),
    .chg_o   (charge_uc),
    .eng_o   (energy_nj),
    .pwr_o   (power_nw)
  );

  assign cpu_sum = {1'b0, cnt_act} + {1'b0, cnt_lpm};

  // R4: the conflict flag is sticky
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    conflict_err |=> conflict_err);
  // R4: a double radio report raises the flag
  a_r4_flag: assert property (@(posedge clk) disable iff (rst)
    (tick_en && tx_on && rx_on) |=> conflict_err);
  // R3: the radio counters never advance together
  a_r3_radio_excl: assert property (@(posedge clk) disable iff (rst)
    (cnt_tx != CNT_TOP && cnt_rx != CNT_TOP) |=>
      !((cnt_tx != $past(cnt_tx)) && (cnt_rx != $past(cnt_rx))));
  // R5: uptime grows by exactly one tick per tick
  a_r5_uptime_step: assert property (@(posedge clk) disable iff (rst)
    (tick_en && cnt_act != CNT_TOP && cnt_lpm != CNT_TOP) |=>
      cpu_sum == $past(cpu_sum) + 1'b1);
endmodule

// File: tb/mode_energy_acc_tb.sv
`timescale 1ns/1ps
module mode_energy_acc_tb;
  localparam int CNT_W = 16;
  localparam int SHIFT = 15;
  localparam logic [127:0] CMAX = (128'd1 << CNT_W) - 1;

  typedef struct packed {
    int unsigned n;
    logic        tx, rx, act, gap;
    logic [15:0] c_tx, c_rx, c_act, c_lpm, volt;
  } vec_t;

  // n ticks with constant modes, gap = idle cycle between ticks
  localparam vec_t VECS [5] = '{
    '{32'd100,   1'b1, 1'b0, 1'b1, 1'b1, 16'd17000, 16'd19700, 16'd1800, 16'd5,  16'd3000},
    '{32'd250,   1'b0, 1'b1, 1'b0, 1'b1, 16'd20000, 16'd21000, 16'd2400, 16'd9,  16'd3300},
    '{32'd50,    1'b1, 1'b1, 1'b1, 1'b0, 16'd65535, 16'd1,     16'd500,  16'd77, 16'd1800},
    '{32'd40000, 1'b0, 1'b0, 1'b0, 1'b0, 16'd12345, 16'd54321, 16'd4000, 16'd40, 16'd3600},
    '{32'd30000, 1'b0, 1'b1, 1'b0, 1'b0, 16'd17000, 16'd19700, 16'd1800, 16'd5,  16'd65535}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic tick_en = 1'b0, tx_on = 1'b0, rx_on = 1'b0, cpu_active = 1'b0, snap_req = 1'b0;
  logic [15:0] coef_tx = '0, coef_rx = '0, coef_act = '0, coef_lpm = '0, volt_mv = '0;
  logic [CNT_W-1:0] cnt_tx, cnt_rx, cnt_act, cnt_lpm;
  logic conflict_err, busy, done;
  logic [18:0] cur_est;
  logic [1:0]  uptime_s;
  logic [20:0] charge_uc;
  logic [36:0] energy_nj;
  logic [34:0] power_nw;

  int n_chk = 0, n_fail = 0;
  logic [127:0] m_cnt [4];
  logic m_err;

  always #4 clk = ~clk;

  mode_energy_acc #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .tx_on(tx_on), .rx_on(rx_on),
    .cpu_active(cpu_active), .coef_tx(coef_tx), .coef_rx(coef_rx),
    .coef_act(coef_act), .coef_lpm(coef_lpm), .volt_mv(volt_mv),
    .snap_req(snap_req), .cnt_tx(cnt_tx), .cnt_rx(cnt_rx), .cnt_act(cnt_act),
    .cnt_lpm(cnt_lpm), .conflict_err(conflict_err), .busy(busy), .done(done),
    .cur_est(cur_est), .uptime_s(uptime_s), .charge_uc(charge_uc),
    .energy_nj(energy_nj), .power_nw(power_nw)
  );

  // reference counters built from the requirements
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) m_cnt[i] <= '0;
      m_err <= 1'b0;
    end else if (tick_en) begin
      if (tx_on) begin
        if (m_cnt[0] != CMAX) m_cnt[0] <= m_cnt[0] + 1;
      end else if (rx_on) begin
        if (m_cnt[1] != CMAX) m_cnt[1] <= m_cnt[1] + 1;
      end
      if (tx_on && rx_on) m_err <= 1'b1;
      if (cpu_active) begin
        if (m_cnt[2] != CMAX) m_cnt[2] <= m_cnt[2] + 1;
      end else begin
        if (m_cnt[3] != CMAX) m_cnt[3] <= m_cnt[3] + 1;
      end
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_counts(input string req);
    check({req, " transmit count"}, 128'(cnt_tx),  m_cnt[0]);
    check({req, " listen count"},   128'(cnt_rx),  m_cnt[1]);
    check({req, " active count"},   128'(cnt_act), m_cnt[2]);
    check({req, " low-power count"},128'(cnt_lpm), m_cnt[3]);
  endtask

  // request a snapshot at a falling edge and verify timing and results
  task automatic run_snap(input bit busy_test);
    logic [127:0] s_cnt [4];
    logic [127:0] s_coef [4];
    logic [127:0] s_volt, ws, cur, ticks, up, chg, eng, pwr;
    int early, extra;
    for (int i = 0; i < 4; i++) s_cnt[i] = m_cnt[i];
    s_coef[0] = 128'(coef_tx); s_coef[1] = 128'(coef_rx);
    s_coef[2] = 128'(coef_act); s_coef[3] = 128'(coef_lpm);
    s_volt = 128'(volt_mv);
    snap_req = 1'b1;
    step();
    snap_req = 1'b0;
    if (busy_test) begin
      coef_tx = 16'd1; coef_rx = 16'd2; coef_act = 16'd3; coef_lpm = 16'd4;
      volt_mv = 16'd5;
    end
    early = 0;
    for (int k = 1; k < 8; k++) begin
      step();
      if (done) early++;
      if (busy_test && k == 2) begin
        check("R12 busy during computation", 128'(busy), 128'd1);
        snap_req = 1'b1;
      end else begin
        snap_req = 1'b0;
      end
    end
    step();
    check("R12 done on 8th edge, none earlier", {126'd0, done, early == 0}, 128'd3);
    ws = 0;
    for (int i = 0; i < 4; i++) ws += s_cnt[i] * s_coef[i];
    cur   = ws >> SHIFT;
    ticks = s_cnt[2] + s_cnt[3];
    up    = ticks >> SHIFT;
    chg   = (cur * ticks) >> SHIFT;
    eng   = chg * s_volt;
    pwr   = cur * s_volt;
    check("R8 current",  128'(cur_est),   cur);
    check("R9 uptime",   128'(uptime_s),  up);
    check("R10 charge",  128'(charge_uc), chg);
    check("R11 energy",  128'(energy_nj), eng);
    check("R11 power",   128'(power_nw),  pwr);
    extra = 0;
    for (int k = 0; k < 12; k++) begin
      step();
      if (done) extra++;
    end
    check(busy_test ? "R13 request while busy ignored" : "R12 done single pulse",
          128'(extra), 128'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    step();
    // R1: reset state
    check("R1 reset tx", 128'(cnt_tx), 0);
    check("R1 reset lpm", 128'(cnt_lpm), 0);
    check("R1 reset flags", {125'd0, conflict_err, busy, done}, 0);
    rst = 1'b0;
    step();

    // table of mode patterns, each followed by a snapshot
    foreach (VECS[v]) begin
      tx_on = VECS[v].tx; rx_on = VECS[v].rx; cpu_active = VECS[v].act;
      coef_tx = VECS[v].c_tx; coef_rx = VECS[v].c_rx;
      coef_act = VECS[v].c_act; coef_lpm = VECS[v].c_lpm; volt_mv = VECS[v].volt;
      for (int t = 0; t < int'(VECS[v].n); t++) begin
        tick_en = 1'b1;
        step();
        if (VECS[v].gap) begin
          tick_en = 1'b0;
          step();
        end
      end
      tick_en = 1'b0;
      // R3 R5 R6 R7 counter contents
      check_counts("R3 R5 R6 R7");
      check("R4 conflict flag", 128'(conflict_err), 128'(m_err));
      run_snap(1'b0);
    end
    // lpm reached saturation in the last table row
    check("R7 saturated low-power", 128'(cnt_lpm), CMAX);

    // R2: modes toggle with no tick, nothing moves
    tx_on = 1'b1; rx_on = 1'b0; cpu_active = 1'b1;
    for (int t = 0; t < 10; t++) begin
      step();
      rx_on = ~rx_on;
    end
    check_counts("R2 no tick");

    // R13: counting and coefficient changes during a computation
    tick_en = 1'b1; tx_on = 1'b1; rx_on = 1'b0; cpu_active = 1'b1;
    coef_tx = 16'd30000; coef_rx = 16'd100; coef_act = 16'd2000; coef_lpm = 16'd3;
    volt_mv = 16'd2500;
    run_snap(1'b1);
    tick_en = 1'b0;
    step();
    check_counts("R13 counting continued");
    check("R4 flag still sticky", 128'(conflict_err), 128'd1);

    // R1: reset clears accumulated state
    rst = 1'b1;
    step();
    rst = 1'b0;
    check_counts("R1 after reset");
    check("R1 flag cleared", 128'(conflict_err), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule